// File: doc/BRIEF.md
# Relocation and Limit Protection Unit

This block sits between a processor and memory in a system where every process lives in one contiguous region. It holds two registers: a relocation value, which is the first physical address of the running process's region, and a limit value, which is the size of that region. For each user-mode access it does two things in the same cycle. It checks the logical address against the limit, and it adds the relocation value to form the physical address. An address at or beyond the limit raises a fault. A faulting address is never presented as valid to memory.

Kernel-mode accesses skip both the check and the relocation and reach all of memory unchanged. Only kernel mode can load the two registers. A load attempted in user mode is dropped and flagged in the same cycle. After reset both registers hold zero, so every user-mode access faults until kernel code loads them.

Each access is placed in one of four classes, and the outputs are selected from that class:
- Idle: no access is offered.
- Kernel pass: a kernel-mode access.
- User granted: a user-mode access inside the limit.
- User trapped: a user-mode access at or beyond the limit.

The class is a function of the current inputs and registers. It is not a stored state, so no transitions exist between classes.

Top module: `reloc_limit_unit`

## Requirements
- R1: After reset the relocation and limit registers both read as zero. As a result, every user-mode access faults and kernel-mode accesses still pass.
- R2: A user-mode access whose logical address is strictly less than the limit gives `phys_valid`=1 and `acc_fault`=0, with `phys_addr` = logical address + relocation value, in the same cycle.
- R3: A user-mode access whose logical address is greater than or equal to the limit gives `acc_fault`=1 and `phys_valid`=0, with `phys_addr` driven to 0, in the same cycle.
- R4: A kernel-mode access gives `phys_addr` equal to the logical address, `phys_valid`=1 and `acc_fault`=0, whatever the register contents.
- R5: A kernel-mode write (`wr_en`=1, `kernel_mode`=1) loads `wr_data` into the relocation register when `wr_sel`=0, or into the limit register when `wr_sel`=1. The new value takes effect from the next cycle.
- R6: A write with `kernel_mode`=0 changes neither register and raises `wr_reject` in the same cycle. `wr_reject` is 0 in every other cycle.
- R7: With `acc_valid`=0, `phys_valid`, `acc_fault` and `phys_addr` are all 0.
- R8: The relocation sum wraps modulo 2^AW and raises no separate indication.
- R9: With a relocation value of 30004 and a limit of 12090, logical address 12089 maps to physical address 42093. Logical address 12090 faults, so no physical address of 42094 or above is reachable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kernel_mode | input | 1 | 1 = kernel mode, 0 = user mode |
| acc_valid | input | 1 | An access is offered this cycle |
| log_addr | input | AW | Logical address of the access |
| wr_en | input | 1 | Register write request |
| wr_sel | input | 1 | 0 = relocation register, 1 = limit register |
| wr_data | input | AW | Value to load |
| phys_addr | output | AW | Physical address sent to memory |
| phys_valid | output | 1 | Physical address may be used by memory |
| acc_fault | output | 1 | User access out of range (trap) |
| wr_reject | output | 1 | Write refused because the mode is user |

## Verification
A user-mode access and a user-mode register write can occur in the same cycle. The access is then translated with the unchanged register values, while `wr_reject` rises beside it. The bench provokes this by presenting a user access together with a user-mode write of a different relocation value. It checks that the physical address and `wr_reject` are correct in that cycle. It then repeats the access in the following cycle to confirm that the relocation value did not move.

// File: rtl/rlu_pkg.sv
package rlu_pkg;
    localparam int NUM_REGS  = 2;
    localparam int REG_RELOC = 0;
    localparam int REG_LIMIT = 1;

    typedef enum logic [1:0] {
        ACC_IDLE     = 2'd0,
        ACC_KERNEL   = 2'd1,
        ACC_USER_OK  = 2'd2,
        ACC_USER_BAD = 2'd3
    } acc_class_e;
endpackage

// File: rtl/rlu_regs.sv
module rlu_regs #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kernel_mode,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [AW-1:0] wr_data,
    output logic [AW-1:0] base_q,
    output logic [AW-1:0] lim_q,
    output logic          wr_reject
);
    import rlu_pkg::*;

    // one storage element per architectural register
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic          hit;
        logic [AW-1:0] q;

        assign hit = wr_en && kernel_mode && (wr_sel == 1'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (hit) begin
                q <= wr_data;
            end
        end
    end

    assign base_q    = g_reg[REG_RELOC].q;
    assign lim_q     = g_reg[REG_LIMIT].q;
    assign wr_reject = wr_en && !kernel_mode;
endmodule

// File: rtl/rlu_classify.sv
module rlu_classify #(
    parameter int AW = 32
) (
    input  logic                acc_valid,
    input  logic                kernel_mode,
    input  logic [AW-1:0]       log_addr,
    input  logic [AW-1:0]       lim_q,
    output rlu_pkg::acc_class_e acc_class
);
    import rlu_pkg::*;

    logic in_range;

    // legal only strictly below the limit
    assign in_range = (log_addr < lim_q);

    always_comb begin
        unique case ({acc_valid, kernel_mode})
            2'b10:   acc_class = in_range ? ACC_USER_OK : ACC_USER_BAD;
            2'b11:   acc_class = ACC_KERNEL;
            default: acc_class = ACC_IDLE;
        endcase
    end
endmodule

// File: rtl/rlu_outsel.sv
module rlu_outsel #(
    parameter int AW = 32
) (
    input  rlu_pkg::acc_class_e acc_class,
    input  logic [AW-1:0]       log_addr,
    input  logic [AW-1:0]       base_q,
    output logic [AW-1:0]       phys_addr,
    output logic                phys_valid,
    output logic                acc_fault
);
    import rlu_pkg::*;

    logic [AW-1:0] reloc_sum;

    // modulo 2^AW, carry out deliberately discarded
    assign reloc_sum = log_addr + base_q;

    always_comb begin
        unique case (acc_class)
            ACC_KERNEL: begin
                phys_addr  = log_addr;
                phys_valid = 1'b1;
                acc_fault  = 1'b0;
            end
            ACC_USER_OK: begin
                phys_addr  = reloc_sum;
                phys_valid = 1'b1;
                acc_fault  = 1'b0;
            end
            ACC_USER_BAD: begin
                phys_addr  = '0;
                phys_valid = 1'b0;
                acc_fault  = 1'b1;
            end
            default: begin
                phys_addr  = '0;
                phys_valid = 1'b0;
                acc_fault  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/reloc_limit_unit.sv
module reloc_limit_unit #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kernel_mode,
    input  logic          acc_valid,
    input  logic [AW-1:0] log_addr,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [AW-1:0] wr_data,
    output logic [AW-1:0] phys_addr,
    output logic          phys_valid,
    output logic          acc_fault,
    output logic          wr_reject
);
    import rlu_pkg::*;

    logic [AW-1:0] base_val;
    logic [AW-1:0] lim_val;
    acc_class_e    acc_class;

    rlu_regs #(.AW(AW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .kernel_mode (kernel_mode),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .base_q      (base_val),
        .lim_q       (lim_val),
        .wr_reject   (wr_reject)
    );

    rlu_classify #(.AW(AW)) u_class (
        .acc_valid   (acc_valid),
        .kernel_mode (kernel_mode),
        .log_addr    (log_addr),
        .lim_q       (lim_val),
        .acc_class   (acc_class)
    );

    rlu_outsel #(.AW(AW)) u_out (
        .acc_class   (acc_class),
        .log_addr    (log_addr),
        .base_q      (base_val),
        .phys_addr   (phys_addr),
        .phys_valid  (phys_valid),
        .acc_fault   (acc_fault)
    );
endmodule

// File: rtl/reloc_limit_chk.sv
module reloc_limit_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          kernel_mode,
    input logic          acc_valid,
    input logic [AW-1:0] log_addr,
    input logic          wr_en,
    input logic          wr_sel,
    input logic [AW-1:0] wr_data,
    input logic [AW-1:0] phys_addr,
    input logic          phys_valid,
    input logic          acc_fault,
    input logic          wr_reject,
    input logic [AW-1:0] base_q,
    input logic [AW-1:0] lim_q
);
    // R3
    valid_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(phys_valid && acc_fault));

    // R3
    fault_hides_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fault |-> (phys_addr == '0));

    // R2
    user_grant_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !kernel_mode) |-> (phys_valid == (log_addr < lim_q)));

    // R4
    kernel_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && kernel_mode) |-> (phys_valid && !acc_fault && phys_addr == log_addr));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (!phys_valid && !acc_fault));

    // R5
    reloc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kernel_mode && !wr_sel) |=> (base_q == $past(wr_data)));

    // R5
    limit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kernel_mode && wr_sel) |=> (lim_q == $past(wr_data)));

    // R6
    user_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && kernel_mode) |=> ($stable(base_q) && $stable(lim_q)));

    // R6
    reject_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject == (wr_en && !kernel_mode));
endmodule

bind reloc_limit_unit reloc_limit_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .kernel_mode (kernel_mode),
    .acc_valid   (acc_valid),
    .log_addr    (log_addr),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .phys_addr   (phys_addr),
    .phys_valid  (phys_valid),
    .acc_fault   (acc_fault),
    .wr_reject   (wr_reject),
    .base_q      (base_val),
    .lim_q       (lim_val)
);

// File: tb/reloc_limit_unit_tb.sv
module reloc_limit_unit_tb;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          kernel_mode = 1'b0;
    logic          acc_valid = 1'b0;
    logic [AW-1:0] log_addr = '0;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [AW-1:0] wr_data = '0;
    logic [AW-1:0] phys_addr;
    logic          phys_valid;
    logic          acc_fault;
    logic          wr_reject;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    reloc_limit_unit #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .kernel_mode(kernel_mode),
        .acc_valid(acc_valid), .log_addr(log_addr), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .phys_addr(phys_addr),
        .phys_valid(phys_valid), .acc_fault(acc_fault), .wr_reject(wr_reject)
    );

    typedef struct packed {
        logic          k;
        logic          v;
        logic [AW-1:0] a;
        logic [AW-1:0] p;
        logic          ev;
        logic          ef;
    } vec_t;

    // relocation 30004, limit 12090 loaded before the walk
    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 32'd0,          32'd30004,      1'b1, 1'b0},
        '{1'b0, 1'b1, 32'd12089,      32'd42093,      1'b1, 1'b0},
        '{1'b0, 1'b1, 32'd12090,      32'd0,          1'b0, 1'b1},
        '{1'b0, 1'b1, 32'd12091,      32'd0,          1'b0, 1'b1},
        '{1'b0, 1'b1, 32'hFFFF_FFFF,  32'd0,          1'b0, 1'b1},
        '{1'b1, 1'b1, 32'd12090,      32'd12090,      1'b1, 1'b0},
        '{1'b1, 1'b1, 32'hFFFF_FFFF,  32'hFFFF_FFFF,  1'b1, 1'b0},
        '{1'b0, 1'b0, 32'd5,          32'd0,          1'b0, 1'b0},
        '{1'b0, 1'b1, 32'd100,        32'd30104,      1'b1, 1'b0}
    };

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic kwrite(input logic sel, input logic [AW-1:0] val);
        @(negedge clk);
        kernel_mode = 1'b1; acc_valid = 1'b0;
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic access(input logic k, input logic v, input logic [AW-1:0] a);
        @(negedge clk);
        kernel_mode = k; acc_valid = v; log_addr = a;
        #1;
    endtask

    task automatic expect_out(input string tag, input logic [AW-1:0] p, input logic ev, input logic ef);
        check({tag, " phys_addr"},  phys_addr, p);
        check({tag, " phys_valid"}, AW'(phys_valid), AW'(ev));
        check({tag, " acc_fault"},  AW'(acc_fault),  AW'(ef));
    endtask

    initial begin : watchdog
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: registers zero after reset, so user faults and kernel passes
        access(1'b0, 1'b1, 32'd0);
        expect_out("R1 user addr 0", 32'd0, 1'b0, 1'b1);
        access(1'b0, 1'b1, 32'd5);
        expect_out("R1 user addr 5", 32'd0, 1'b0, 1'b1);
        access(1'b1, 1'b1, 32'd7);
        expect_out("R1 kernel addr 7", 32'd7, 1'b1, 1'b0);
        check("R6 reject idle", AW'(wr_reject), '0);

        // R5: load relocation and limit from kernel mode
        kwrite(1'b0, 32'd30004);
        kwrite(1'b1, 32'd12090);

        // R2 R3 R4 R7 R9: table walk
        for (int i = 0; i < NV; i++) begin
            access(VECS[i].k, VECS[i].v, VECS[i].a);
            expect_out($sformatf("R2/R3/R4/R7/R9 vec %0d", i), VECS[i].p, VECS[i].ev, VECS[i].ef);
        end

        // R5: limit reload seen on the next access
        kwrite(1'b1, 32'd200);
        access(1'b0, 1'b1, 32'd199);
        expect_out("R5 new limit edge", 32'd30203, 1'b1, 1'b0);
        access(1'b0, 1'b1, 32'd200);
        expect_out("R5 new limit fault", 32'd0, 1'b0, 1'b1);

        // R8: wrap of the relocation sum
        kwrite(1'b0, 32'hFFFF_FFF0);
        access(1'b0, 1'b1, 32'h20);
        expect_out("R8 wrap", 32'h10, 1'b1, 1'b0);

        // R6: user access and user write in the same cycle
        @(negedge clk);
        kernel_mode = 1'b0; acc_valid = 1'b1; log_addr = 32'h30;
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h1000;
        #1;
        check("R6 reject flag", AW'(wr_reject), AW'(1));
        expect_out("R6 concurrent access", 32'h20, 1'b1, 1'b0);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'd5;
        #1;
        check("R6 reject flag limit", AW'(wr_reject), AW'(1));
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R6 reject clears", AW'(wr_reject), '0);
        expect_out("R6 registers kept", 32'h20, 1'b1, 1'b0);
        access(1'b0, 1'b1, 32'd199);
        expect_out("R6 limit kept", 32'd199 + 32'hFFFF_FFF0, 1'b1, 1'b0);

        // R7: idle in user mode with a wild address
        access(1'b0, 1'b0, 32'hDEAD_BEEF);
        expect_out("R7 idle", 32'd0, 1'b0, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule